// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block keeps the eight-bit status byte of a serial memory and decides, one request at a time, whether a status update or a data-array write may go ahead. An SPI front end that has already decoded each command raises a one-cycle pulse: set-enable, clear-enable, status update (with its data byte), or array write (with a 19-bit byte address). The block answers each request with a grant in the same cycle. It also presents the status byte for the status-read command.

Three things gate a write. The first is the write-enable latch. The second is the lock bit in the status byte. The third is the external write-protect pin, where low means protect. A two-bit block field selects how much of the top of the address space is shielded from array writes. The lock bit, the block field and four spare bits model nonvolatile cells. Power-on reset does not clear them, and they start at zero. Only the write-enable latch returns to zero on reset.

Top module: `swp_guard`

## Requirements
- R1: After reset the status byte reads 00h and both grant outputs are low.
- R2: A set-enable pulse makes status bit 1 (write-enable latch) read 1 from the next cycle. A clear-enable pulse makes it read 0 from the next cycle.
- R3: While the latch is 0, neither grant is ever raised and a status update request changes no bit.
- R4: With the latch at 1, a status update is granted when bit 7 (lock) is 0 or the protect pin is high. From the next cycle, bits 7, 6, 5, 4, 3, 2 and 0 of the status byte take the data byte's values.
- R5: When the lock bit is 1 and the protect pin is low, a status update is refused and every status bit stays as it was. Raising the pin makes the status byte writable again.
- R6: Bits 3:2 select the shielded region of the 512K space: 00 none, 01 addresses 60000h-7FFFFh, 10 addresses 40000h-7FFFFh, 11 all. An array write is granted in its request cycle exactly when the latch is 1 and the address lies outside that region.
- R7: A reset clears only bit 1. All the other status bits keep their values across it.
- R8: Bits 6, 5, 4 and 0 are stored and read back but have no effect on any grant.
- R9: When set-enable and clear-enable arrive in the same cycle, the latch ends at 0.
- R10: Bit 1 of a status update's data byte is ignored. The latch keeps its value through a granted update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wren_i | input | 1 | Set-enable command pulse |
| wrdi_i | input | 1 | Clear-enable command pulse |
| wrsr_i | input | 1 | Status update request pulse |
| wrsr_data_i | input | 8 | Data byte of the status update |
| wr_req_i | input | 1 | Array write request pulse |
| wr_addr_i | input | 19 | Byte address of the array write |
| wp_pin_i | input | 1 | Write-protect pin, low protects |
| status_o | output | 8 | Status byte for the status-read command |
| sr_grant_o | output | 1 | Status update permitted (same cycle as request) |
| wr_grant_o | output | 1 | Array write permitted (same cycle as request) |

## Verification
Both grants are combinational on the request and on the registered state, so they are due in the request cycle itself. The bench samples them one time step after it drives the inputs on the falling edge. Changes to the status byte pass through one register and appear after the next rising edge. The bench reads the byte at the following falling edge, once the request has been removed. Each region boundary is probed with the last address allowed and the first address shielded, and lock and hardware protection are tried at both pin levels.

// File: rtl/swp_pkg.sv
package swp_pkg;
    localparam int ST_W = 8;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic       lock_en;   // bit 7
        logic [2:0] spare_hi;  // bits 6:4
        bp_e        bp;        // bits 3:2
        logic       wel;       // bit 1
        logic       spare_lo;  // bit 0
    } status_t;

    function automatic logic sr_write_ok(logic wel, logic lock_en, logic wp_pin);
        return wel && (!lock_en || wp_pin);
    endfunction

    function automatic logic region_hit(bp_e bp, logic [1:0] top2);
        case (bp)
            BP_NONE:    return 1'b0;
            BP_QUARTER: return top2 == 2'b11;
            BP_HALF:    return top2[1];
            default:    return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/swp_wel.sv
module swp_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    always_ff @(posedge clk) begin
        if (rst)        wel_o <= 1'b0;
        else if (clr_i) wel_o <= 1'b0;
        else if (set_i) wel_o <= 1'b1;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wel_o) |-> $past(set_i));
    assert_clr_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !wel_o);
endmodule

// File: rtl/swp_nvstore.sv
module swp_nvstore
    import swp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wrsr_i,
    input  status_t data_i,
    input  logic    wel_i,
    input  logic    wp_pin_i,
    output logic    grant_o,
    output status_t nv_o
);
    status_t nv_q = '0;

    assign grant_o = wrsr_i && sr_write_ok(wel_i, nv_q.lock_en, wp_pin_i);

    always_ff @(posedge clk) begin
        if (grant_o) begin
            nv_q     <= data_i;
            nv_q.wel <= 1'b0;
        end
    end

    assign nv_o = nv_q;

    assert_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (wrsr_i && nv_q.lock_en && !wp_pin_i) |=> $stable(nv_q));
    assert_nowel_R3: assert property (@(posedge clk) disable iff (rst)
        (wrsr_i && !wel_i) |=> $stable(nv_q));
endmodule

// File: rtl/swp_region.sv
module swp_region
    import swp_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  bp_e               bp_i,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign hit_o = region_hit(bp_i, addr_i[TOP -: 2]);
        end else begin : g_narrow
            assign hit_o = region_hit(bp_i, {addr_i[0], addr_i[0]});
        end
    endgenerate
endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [ST_W-1:0]   wrsr_data_i,
    input  logic              wr_req_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wp_pin_i,
    output logic [ST_W-1:0]   status_o,
    output logic              sr_grant_o,
    output logic              wr_grant_o
);
    logic    wel;
    logic    hit;
    status_t nv;
    status_t shown;

    swp_wel u_wel (
        .clk   (clk),
        .rst   (rst),
        .set_i (wren_i),
        .clr_i (wrdi_i),
        .wel_o (wel)
    );

    swp_nvstore u_nv (
        .clk      (clk),
        .rst      (rst),
        .wrsr_i   (wrsr_i),
        .data_i   (status_t'(wrsr_data_i)),
        .wel_i    (wel),
        .wp_pin_i (wp_pin_i),
        .grant_o  (sr_grant_o),
        .nv_o     (nv)
    );

    swp_region #(.ADDR_W(ADDR_W)) u_region (
        .addr_i (wr_addr_i),
        .bp_i   (nv.bp),
        .hit_o  (hit)
    );

    always_comb begin
        shown     = nv;
        shown.wel = wel;
    end

    assign status_o   = shown;
    assign wr_grant_o = wr_req_i && wel && !hit;

    assert_nogrant_R3: assert property (@(posedge clk) disable iff (rst)
        !wel |-> (!wr_grant_o && !sr_grant_o));
    assert_all_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_req_i && status_o[3:2] == 2'b11) |-> !wr_grant_o);
    assert_keep_wel_R10: assert property (@(posedge clk) disable iff (rst)
        (wrsr_i && !wren_i && !wrdi_i) |=> (status_o[1] == $past(status_o[1])));
endmodule

// File: tb/swp_guard_tb.sv
module swp_guard_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wren = 0, wrdi = 0, wrsr = 0, wr_req = 0, wp = 1;
    logic [7:0]  sr_data = '0;
    logic [18:0] addr = '0;
    logic [7:0]  status;
    logic        sr_grant, wr_grant;
    logic        got_sr, got_wr;
    int          checks = 0, errors = 0;
    logic [7:0]  exp_st = 8'h00;

    always #(PERIOD/2) clk = ~clk;

    swp_guard u_dut (
        .clk(clk), .rst(rst), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
        .wrsr_data_i(sr_data), .wr_req_i(wr_req), .wr_addr_i(addr),
        .wp_pin_i(wp), .status_o(status), .sr_grant_o(sr_grant),
        .wr_grant_o(wr_grant)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one request cycle from a falling edge, captures grants, clears inputs.
    task automatic step(logic en, logic di, logic sr, logic [7:0] d,
                        logic rq, logic [18:0] a);
        wren = en; wrdi = di; wrsr = sr; sr_data = d; wr_req = rq; addr = a;
        #1;
        got_sr = sr_grant; got_wr = wr_grant;
        @(posedge clk); @(negedge clk);
        wren = 0; wrdi = 0; wrsr = 0; wr_req = 0;
    endtask

    task automatic t_reset;
        step(0, 0, 0, 8'h00, 1, 19'h0);
        chk("R1 status", status, 8'h00);
        chk("R1 wr_grant", got_wr, 0);
    endtask

    task automatic t_wel_gate;
        step(0, 0, 1, 8'h0C, 0, 19'h0);
        chk("R3 sr_grant", got_sr, 0);
        chk("R3 status", status, 8'h00);
        step(0, 0, 0, 8'h00, 1, 19'h12345);
        chk("R3 wr_grant", got_wr, 0);
    endtask

    task automatic t_wel_cmds;
        step(1, 0, 0, 8'h00, 0, 19'h0);
        chk("R2 set", status, 8'h02);
        step(0, 1, 0, 8'h00, 0, 19'h0);
        chk("R2 clear", status, 8'h00);
        step(1, 0, 0, 8'h00, 0, 19'h0);
        step(1, 1, 0, 8'h00, 0, 19'h0);
        chk("R9 both", status, 8'h00);
    endtask

    task automatic t_wrsr;
        step(1, 0, 0, 8'h00, 0, 19'h0);
        step(0, 0, 1, 8'hF5, 0, 19'h0);
        chk("R4 grant", got_sr, 1);
        chk("R10 status", status, 8'hF7);
    endtask

    task automatic t_lock;
        wp = 0;
        step(0, 0, 1, 8'h00, 0, 19'h0);
        chk("R5 refused", got_sr, 0);
        chk("R5 unchanged", status, 8'hF7);
        wp = 1;
        step(0, 0, 1, 8'h08, 0, 19'h0);
        chk("R5 pin high grant", got_sr, 1);
        chk("R5 pin high status", status, 8'h0A);
        wp = 0;
        step(0, 0, 1, 8'h8C, 0, 19'h0);
        chk("R4 unlocked pin low", got_sr, 1);
        chk("R4 status", status, 8'h8E);
        step(0, 0, 1, 8'h00, 0, 19'h0);
        chk("R5 hw protect", status, 8'h8E);
        wp = 1;
    endtask

    task automatic t_regions;
        step(0, 0, 1, 8'h00, 0, 19'h0);
        step(0, 0, 0, 8'h00, 1, 19'h7FFFF);
        chk("R6 none top", got_wr, 1);
        step(0, 0, 1, 8'h04, 0, 19'h0);
        step(0, 0, 0, 8'h00, 1, 19'h5FFFF);
        chk("R6 quarter below", got_wr, 1);
        step(0, 0, 0, 8'h00, 1, 19'h60000);
        chk("R6 quarter in", got_wr, 0);
        step(0, 0, 1, 8'h75, 0, 19'h0);
        step(0, 0, 0, 8'h00, 1, 19'h5FFFF);
        chk("R8 spare below", got_wr, 1);
        step(0, 0, 0, 8'h00, 1, 19'h60000);
        chk("R8 spare in", got_wr, 0);
        step(0, 0, 1, 8'h08, 0, 19'h0);
        step(0, 0, 0, 8'h00, 1, 19'h3FFFF);
        chk("R6 half below", got_wr, 1);
        step(0, 0, 0, 8'h00, 1, 19'h40000);
        chk("R6 half in", got_wr, 0);
        step(0, 0, 1, 8'h0C, 0, 19'h0);
        step(0, 0, 0, 8'h00, 1, 19'h00000);
        chk("R6 all", got_wr, 0);
    endtask

    task automatic t_nv_keep;
        step(0, 0, 1, 8'hB9, 0, 19'h0);
        chk("R7 before", status, 8'hBB);
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        chk("R7 after reset", status, 8'hB9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_wel_gate();
        t_wel_cmds();
        t_wrsr();
        t_lock();
        t_regions();
        t_nv_keep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule